// File: doc/BRIEF.md
# Uncore Event Counter Bank

This block is a bank of eight 64-bit performance counters placed next to a shared cache or interconnect slice. Each counter is steered to one line of an event vector by an 8-bit code held in a select register. Each clock cycle in which the chosen event line is high, the counter advances by one. A counter only runs while both a bank-wide run bit and its own enable bit are set. Event qualification, such as source or target filtering, happens upstream, so the event lines arrive already gated.

Software reaches the bank through a single-cycle register port. The data path is 64 bits wide. Counters are read and written as whole 64-bit words. All other registers use the low 32 bits and read back zero-extended. Register reads are combinational from the address. A write takes effect at the next rising edge.

When a counter rolls over from all ones to zero, its pending bit is latched. The interrupt line is raised for any pending bit whose mask bit is clear. Software removes pending bits by writing ones to a clear register.

Top module: `evcb_bank`

## Requirements
- R1: After reset, every register reads zero, with two exceptions: the interrupt mask at 0x0814 reads 0xFF, and the version register at 0x1CF0 reads the VERSION parameter. The irq output is low.
- R2: Counter n is located at byte address 0x1D00 + 8*n. It is written and read back as a full 64-bit value.
- R3: The select register at 0x1C18 holds the codes for counters 0 to 3. The one at 0x1C1C holds the codes for counters 4 to 7. Counter n uses bits [8*(n%4)+7 : 8*(n%4)] of its register.
- R4: Counter n is incremented at a rising edge when three conditions hold in the preceding cycle: bit 0 of 0x1C00 is 1, bit n of 0x1C14 is 1, and evt_in[code] is 1, where code is the counter's select code.
- R5: While bit 0 of 0x1C00 is 0, no counter changes, whatever the event inputs are.
- R6: While bit n of 0x1C14 is 0, counter n does not change, while the other enabled counters keep counting.
- R7: A select code from 0x80 to 0xFF never counts. This holds even when every event input is high.
- R8: When a counter is written in the same cycle as an increment condition, the counter takes the written value.
- R9: When counter n wraps from all ones to zero, bit n of the status register at 0x0818 is set at that same edge. Writes to 0x0818 have no effect.
- R10: In the mask register at 0x0814, bit n = 1 masks counter n. irq is high exactly when some status bit is set and its mask bit is 0.
- R11: Writing 1 to bit n of 0x081C clears status bit n. Writing 0 to a bit leaves that status bit unchanged.
- R12: Writes to the version register have no effect on its read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 64 | Write data; registers other than counters use bits 31:0 |
| bus_rdata | output | 64 | Combinational read data for bus_addr |
| evt_in | input | 128 | Event lines, indexed by the low 7 bits of a select code |
| irq | output | 1 | Overflow interrupt, active high |

## Verification
Read data is combinational, so it is due in the same cycle the address is presented. The bench samples it 1 ns after driving the address on a falling edge.

A write or an event presented during one cycle becomes visible at the first rising edge after it. This applies to register contents, counter values, status bits and irq alike. The bench therefore drives each stimulus for exactly one falling-to-falling window and only reads back afterwards.

An overflow sets its status bit at the same edge the counter wraps. As a result, the status bit and the zeroed counter are checked together. The irq line is checked after each mask or clear write has taken effect.

// File: rtl/evcb_pkg.sv
package evcb_pkg;

    localparam int ADDR_W = 16;
    localparam int BUS_W  = 64;
    localparam int REG_W  = 32;

    localparam logic [ADDR_W-1:0] A_IMASK = 16'h0814;
    localparam logic [ADDR_W-1:0] A_ISTAT = 16'h0818;
    localparam logic [ADDR_W-1:0] A_ICLR  = 16'h081C;
    localparam logic [ADDR_W-1:0] A_RUN   = 16'h1C00;
    localparam logic [ADDR_W-1:0] A_CEN   = 16'h1C14;
    localparam logic [ADDR_W-1:0] A_SEL0  = 16'h1C18;
    localparam logic [ADDR_W-1:0] A_VER   = 16'h1CF0;
    localparam logic [ADDR_W-1:0] A_CNT0  = 16'h1D00;

    typedef struct packed {
        logic              wen;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  wdata;
    } bus_req_t;

    function automatic logic cnt_hit(input logic [ADDR_W-1:0] addr, input int n);
        return addr == (A_CNT0 + ADDR_W'(8 * n));
    endfunction

    function automatic logic sel_hit(input logic [ADDR_W-1:0] addr, input int k);
        return addr == (A_SEL0 + ADDR_W'(4 * k));
    endfunction

endpackage

// File: rtl/evcb_regfile.sv
module evcb_regfile
    import evcb_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int CODE_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  bus_req_t                       req,
    output logic                           run_en,
    output logic [NUM_CTR-1:0]             ctr_en,
    output logic [NUM_CTR-1:0]             mask,
    output logic [NUM_CTR-1:0][CODE_W-1:0] codes
);
    localparam int PER_SEL = REG_W / CODE_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_en <= 1'b0;
            ctr_en <= '0;
            mask   <= '1;
            codes  <= '0;
        end else if (req.wen) begin
            if (req.addr == A_RUN)   run_en <= req.wdata[0];
            if (req.addr == A_CEN)   ctr_en <= req.wdata[NUM_CTR-1:0];
            if (req.addr == A_IMASK) mask   <= req.wdata[NUM_CTR-1:0];
            for (int n = 0; n < NUM_CTR; n++) begin
                if (sel_hit(req.addr, n / PER_SEL))
                    codes[n] <= req.wdata[CODE_W*(n%PER_SEL) +: CODE_W];
            end
        end
    end

endmodule

// File: rtl/evcb_counter.sv
module evcb_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);
    assign wrap = inc && !ld && (&value);

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (ld)
            value <= ld_val;
        else if (inc)
            value <= value + W'(1);
    end

endmodule

// File: rtl/evcb_irq.sv
module evcb_irq #(
    parameter int NUM_CTR = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CTR-1:0] wrap,
    input  logic               clr_wen,
    input  logic [NUM_CTR-1:0] clr_bits,
    input  logic [NUM_CTR-1:0] mask,
    output logic [NUM_CTR-1:0] status,
    output logic               irq
);
    logic [NUM_CTR-1:0] clr_eff;

    assign clr_eff = clr_wen ? clr_bits : '0;
    assign irq     = |(status & ~mask);

    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else
            status <= (status & ~clr_eff) | wrap;
    end

endmodule

// File: rtl/evcb_bank.sv
module evcb_bank
    import evcb_pkg::*;
#(
    parameter int          NUM_CTR = 8,
    parameter int          CTR_W   = 64,
    parameter int          CODE_W  = 8,
    parameter logic [31:0] VERSION = 32'h0000_0201
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wen,
    input  logic [15:0]                 bus_addr,
    input  logic [63:0]                 bus_wdata,
    output logic [63:0]                 bus_rdata,
    input  logic [(1<<(CODE_W-1))-1:0]  evt_in,
    output logic                        irq
);
    localparam int PER_SEL = REG_W / CODE_W;

    bus_req_t                       req;
    logic                           run_en;
    logic [NUM_CTR-1:0]             ctr_en;
    logic [NUM_CTR-1:0]             mask;
    logic [NUM_CTR-1:0]             status;
    logic [NUM_CTR-1:0]             wrap;
    logic [NUM_CTR-1:0][CODE_W-1:0] codes;
    logic [NUM_CTR-1:0][CTR_W-1:0]  ctr_val;
    logic                           clr_wen;

    assign req     = '{wen: bus_wen, addr: bus_addr, wdata: bus_wdata};
    assign clr_wen = bus_wen && (bus_addr == A_ICLR);

    evcb_regfile #(.NUM_CTR(NUM_CTR), .CODE_W(CODE_W)) regs_i (
        .clk(clk), .rst(rst), .req(req),
        .run_en(run_en), .ctr_en(ctr_en), .mask(mask), .codes(codes)
    );

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
        logic in_range;
        logic inc;
        logic ld;
        assign in_range = !codes[n][CODE_W-1];
        assign inc      = run_en && ctr_en[n] && in_range && evt_in[codes[n][CODE_W-2:0]];
        assign ld       = bus_wen && cnt_hit(bus_addr, n);

        evcb_counter #(.W(CTR_W)) ctr_i (
            .clk(clk), .rst(rst), .ld(ld), .ld_val(bus_wdata[CTR_W-1:0]),
            .inc(inc), .value(ctr_val[n]), .wrap(wrap[n])
        );
    end

    evcb_irq #(.NUM_CTR(NUM_CTR)) irq_i (
        .clk(clk), .rst(rst), .wrap(wrap), .clr_wen(clr_wen),
        .clr_bits(bus_wdata[NUM_CTR-1:0]), .mask(mask),
        .status(status), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_RUN)   bus_rdata[0]           = run_en;
        if (bus_addr == A_CEN)   bus_rdata[NUM_CTR-1:0] = ctr_en;
        if (bus_addr == A_IMASK) bus_rdata[NUM_CTR-1:0] = mask;
        if (bus_addr == A_ISTAT) bus_rdata[NUM_CTR-1:0] = status;
        if (bus_addr == A_VER)   bus_rdata[31:0]        = VERSION;
        for (int n = 0; n < NUM_CTR; n++) begin
            if (cnt_hit(bus_addr, n))
                bus_rdata[CTR_W-1:0] = ctr_val[n];
            if (sel_hit(bus_addr, n / PER_SEL))
                bus_rdata[CODE_W*(n%PER_SEL) +: CODE_W] = codes[n];
        end
    end

endmodule

// File: rtl/evcb_checker.sv
module evcb_checker
    import evcb_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int CTR_W   = 64,
    parameter int CODE_W  = 8
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           bus_wen,
    input logic [15:0]                    bus_addr,
    input logic [63:0]                    bus_wdata,
    input logic                           irq,
    input logic                           run_en,
    input logic [NUM_CTR-1:0][CODE_W-1:0] codes,
    input logic [NUM_CTR-1:0][CTR_W-1:0]  ctr_val,
    input logic [NUM_CTR-1:0]             wrap,
    input logic [NUM_CTR-1:0]             status
);
    // R5
    run_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !bus_wen) |=> $stable(ctr_val));

    // R10
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |-> !irq);

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_chk
        // R9
        wrap_status_chk: assert property (@(posedge clk) disable iff (rst)
            wrap[n] |=> status[n]);

        // R8
        load_prio_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wen && cnt_hit(bus_addr, n)) |=> (ctr_val[n] == $past(bus_wdata[CTR_W-1:0])));

        // R7
        bad_code_chk: assert property (@(posedge clk) disable iff (rst)
            (codes[n][CODE_W-1] && !bus_wen) |=> $stable(ctr_val[n]));

        // R11
        clear_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wen && bus_addr == A_ICLR && bus_wdata[n] && !wrap[n]) |=> !status[n]);
    end

endmodule

bind evcb_bank evcb_checker #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .CODE_W(CODE_W)) chk_i (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .irq(irq), .run_en(run_en), .codes(codes), .ctr_val(ctr_val), .wrap(wrap), .status(status)
);

// File: tb/evcb_bank_tb.sv
module evcb_bank_tb_top;

    localparam logic [31:0] VER = 32'h0000_0201;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wen = 1'b0;
    logic [15:0]  bus_addr = '0;
    logic [63:0]  bus_wdata = '0;
    logic [63:0]  bus_rdata;
    logic [127:0] evt_in = '0;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] exp_c [8];
    logic        m_run;
    logic [7:0]  m_en;
    logic [7:0]  m_code [8];

    always #2.5 clk = ~clk;

    evcb_bank #(.VERSION(VER)) dut_i (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq)
    );

    function automatic logic [7:0] code_of(input int m);
        case (m)
            0: return 8'h09; 1: return 8'h30; 2: return 8'h31; 3: return 8'h34;
            4: return 8'h35; 5: return 8'h00; 6: return 8'h5A; default: return 8'h7F;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
        if (a >= 16'h1D00 && a < 16'h1D40 && a[2:0] == 3'd0) exp_c[(a - 16'h1D00) >> 3] = d;
    endtask

    task automatic rd(input logic [15:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [127:0] v, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            evt_in = v;
            for (int m = 0; m < 8; m++)
                if (m_run && m_en[m] && !m_code[m][7] && v[m_code[m][6:0]])
                    exp_c[m] = exp_c[m] + 64'd1;
        end
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic check_all(input string req);
        logic [63:0] d;
        for (int m = 0; m < 8; m++) begin
            rd(16'h1D00 + 16'(8 * m), d);
            chk(req, d, exp_c[m]);
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5ns * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [63:0] d;
        logic [63:0] pat;
        for (int m = 0; m < 8; m++) begin exp_c[m] = '0; m_code[m] = '0; end
        m_run = 1'b0; m_en = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(16'h0814, d); chk("R1 mask", d, 64'hFF);
        rd(16'h0818, d); chk("R1 status", d, 64'h0);
        rd(16'h1C00, d); chk("R1 run", d, 64'h0);
        rd(16'h1C14, d); chk("R1 enables", d, 64'h0);
        rd(16'h1C18, d); chk("R1 select", d, 64'h0);
        rd(16'h1CF0, d); chk("R1 version", d, {32'h0, VER});
        chk("R1 irq", {63'h0, irq}, 64'h0);
        check_all("R1 counters");

        // R12 version ignores writes
        wr(16'h1CF0, 64'hDEAD_BEEF);
        rd(16'h1CF0, d); chk("R12 version", d, {32'h0, VER});

        // R2 full-width counter access
        for (int m = 0; m < 8; m++) begin
            pat = 64'hF0E1_D2C3_0000_0000 + (64'(m) << 40) + 64'(3 * m + 1);
            wr(16'h1D00 + 16'(8 * m), pat);
        end
        check_all("R2 readback");
        for (int m = 0; m < 8; m++) wr(16'h1D00 + 16'(8 * m), 64'h0);
        check_all("R2 zero");

        // R3 code packing
        for (int m = 0; m < 8; m++) m_code[m] = code_of(m);
        wr(16'h1C18, {32'h0, code_of(3), code_of(2), code_of(1), code_of(0)});
        wr(16'h1C1C, {32'h0, code_of(7), code_of(6), code_of(5), code_of(4)});
        rd(16'h1C18, d); chk("R3 sel0", d, 64'h3431_3009);
        rd(16'h1C1C, d); chk("R3 sel1", d, 64'h7F5A_0035);

        // R4 sweep: each counter gets its own event for m+2 cycles
        wr(16'h1C14, 64'hFF); m_en = 8'hFF;
        wr(16'h1C00, 64'h1);  m_run = 1'b1;
        for (int m = 0; m < 8; m++) begin
            pulse(128'd1 << code_of(m), m + 2);
            check_all("R4 sweep");
        end

        // R5 run bit off freezes everything
        wr(16'h1C00, 64'h0); m_run = 1'b0;
        pulse('1, 3);
        check_all("R5 run off");

        // R6 per-counter enable
        wr(16'h1C00, 64'h1);  m_run = 1'b1;
        wr(16'h1C14, 64'hFE); m_en = 8'hFE;
        pulse('1, 2);
        check_all("R6 enable off");

        // R7 out-of-range code for counter 4
        m_code[4] = 8'h89;
        wr(16'h1C1C, {32'h0, code_of(7), code_of(6), code_of(5), 8'h89});
        pulse('1, 2);
        check_all("R7 bad code");

        // R8 write wins over same-cycle increment
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = 16'h1D10; bus_wdata = 64'h55;
        evt_in = 128'd1 << code_of(2);
        @(negedge clk);
        bus_wen = 1'b0; evt_in = '0;
        exp_c[2] = 64'h55;
        rd(16'h1D10, d); chk("R8 priority", d, 64'h55);

        // R9 wrap sets status
        wr(16'h1D30, '1);
        pulse(128'd1 << code_of(6), 1);
        rd(16'h1D30, d); chk("R9 wrapped", d, 64'h0);
        rd(16'h0818, d); chk("R9 status", d, 64'h40);
        wr(16'h0818, 64'h0);
        rd(16'h0818, d); chk("R9 status write ignored", d, 64'h40);
        chk("R10 masked irq", {63'h0, irq}, 64'h0);

        // R10 unmask
        wr(16'h0814, 64'hBF);
        #1 chk("R10 unmasked irq", {63'h0, irq}, 64'h1);
        wr(16'h0814, 64'h40);
        #1 chk("R10 other bits unmasked", {63'h0, irq}, 64'h0);
        wr(16'h0814, 64'hBF);

        // R11 clear
        wr(16'h081C, 64'hBF);
        rd(16'h0818, d); chk("R11 zero bits keep", d, 64'h40);
        #1 chk("R11 irq kept", {63'h0, irq}, 64'h1);
        wr(16'h081C, 64'h40);
        rd(16'h0818, d); chk("R11 cleared", d, 64'h0);
        #1 chk("R11 irq dropped", {63'h0, irq}, 64'h0);

        summary();
    end

endmodule